// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a W-bit data stream by a fixed number N of shift steps. The words sit in an addressed storage array and do not pass through a chain of registers. On every enabled shift, the incoming word is written at one address and an older word is read from another. Two circular addresses then step forward by one. The data stays where it was written, and only the addresses move. A long delay therefore costs one array word per stage plus a small amount of pointer logic, instead of W flip-flops per stage.

The user drives `shift_en` high on each cycle that should advance the line and presents the new word on `din`. The output `dout` is registered, and it behaves exactly like the last stage of an N-deep register chain that was cleared at reset. Stalled cycles are free: with `shift_en` low, nothing moves.

Top module: `delay_line_ram`

## Requirements
- R1: While `rst_n` is low, `dout` is zero. The read address restarts at entry 0 and the write address restarts at entry N-1.
- R2: A word sampled from `din` on an enabled shift appears on `dout` right after the edge of the (N-1)-th enabled shift that follows it. The word therefore reaches the output N enabled edges after its own edge is counted, the same as an N-stage register chain.
- R3: Until N enabled shifts have happened since reset, `dout` is zero.
- R4: On a clock edge with `shift_en` low, `dout` and both addresses keep their values, and the `din` value on that edge is never delivered to `dout`.
- R5: Both addresses wrap from N-1 back to 0. Delays that are not a power of two (such as 12) keep the exact latency over many laps of the array.
- R6: Each enabled shift advances each address by exactly one, modulo N. The write address always stays N-1 entries ahead of the read address, modulo N.
- R7: The smallest delay, N = 2, gives the same chain behaviour as any larger N.
- R8: Asserting reset in the middle of a stream clears `dout` and restarts the fill, so earlier words never reappear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| shift_en | input | 1 | Advances the line by one step when high |
| din | input | W | Word entering the line |
| dout | output | W | Word leaving the line, registered |

## Verification
The bench targets the off-by-one edges of the latency. It uses a delay of 12, which is not a power of two, so a pointer that wraps at the next power of two drifts by several stages after the first lap. A wrong starting offset between the two addresses shows up as a latency of N-1 or N+1 on the very first valid word. Stalls that still write or still advance an address let a stalled `din` leak into the output or shift all later data by one. Words that appear early during the fill, or that survive a reset mid-stream, expose a missing fill gate. A second instance with N = 2 catches designs where the read and write addresses collide.

// File: rtl/delay_line_pkg.sv
package delay_line_pkg;

  // Address width for a circular pointer over `depth` entries (at least 1).
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction

  // Width of a counter that must reach `limit` inclusive.
  function automatic int unsigned count_bits(input int unsigned limit);
    return (limit <= 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/dl_ptr_ctr.sv
// Circular address counter: steps by one on adv, wraps at DEPTH-1.
module dl_ptr_ctr #(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned AW        = 6,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] START = AW'(RESET_VAL);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (ptr_q == LAST) ptr_d = '0;
      else               ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= START;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/dl_fill_tracker.sv
// Counts enabled shifts after reset, saturating once the array holds
// written data at the read address for the next shift.
module dl_fill_tracker #(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic primed
);

  localparam int unsigned CW = delay_line_pkg::count_bits(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv && (cnt_q != FULL)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign primed = (cnt_q == FULL);

endmodule

// File: rtl/dl_sram_1r1w.sv
// Simple storage array: one synchronous write port, one registered read port.
module dl_sram_1r1w #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/delay_line_ram.sv
// Fixed N-stage delay line held in a storage array; pointers move, data does not.
module delay_line_ram #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int unsigned AW = delay_line_pkg::addr_bits(N);

  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [W-1:0]  rdata;
  logic          primed;
  logic          valid_q, valid_d;

  // Read starts at the first entry, write at the last: a word written on
  // shift j is read back on shift j+N-1 and shown after that edge.
  dl_ptr_ctr #(.DEPTH(N), .AW(AW), .RESET_VAL(0)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .adv(shift_en), .ptr(rd_ptr)
  );

  dl_ptr_ctr #(.DEPTH(N), .AW(AW), .RESET_VAL(N - 1)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .adv(shift_en), .ptr(wr_ptr)
  );

  dl_fill_tracker #(.DEPTH(N)) u_fill (
    .clk(clk), .rst_n(rst_n), .adv(shift_en), .primed(primed)
  );

  dl_sram_1r1w #(.W(W), .DEPTH(N), .AW(AW)) u_mem (
    .clk(clk), .we(shift_en), .waddr(wr_ptr), .wdata(din),
    .re(shift_en), .raddr(rd_ptr), .rdata(rdata)
  );

  // Marks whether the word held in the read register came from written data.
  always_comb begin
    valid_d = valid_q;
    if (shift_en) valid_d = primed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign dout = valid_q ? rdata : '0;

endmodule

// File: rtl/delay_line_chk.sv
module delay_line_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned N  = 64,
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_en,
  input logic [W-1:0]  dout,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] wr_ptr
);

  localparam int unsigned SW = delay_line_pkg::count_bits(N);

  logic [SW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               seen_q <= '0;
    else if (shift_en && (int'(seen_q) < N))  seen_q <= seen_q + 1'b1;
  end

  // R3
  fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(seen_q) < N) |-> (dout == '0));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> ($stable(dout) && $stable(rd_ptr) && $stable(wr_ptr)));

  // R6
  ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(rd_ptr) + N - 1) % N) == int'(wr_ptr));

  // R6
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (int'(rd_ptr) == ((int'($past(rd_ptr)) + 1) % N)));

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_ptr) < N) && (int'(wr_ptr) < N));

endmodule

bind delay_line_ram delay_line_chk #(.W(W), .N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .dout(dout),
  .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/tb_delay_line_ram.sv
module tb_delay_line_ram;

  localparam int W    = 8;
  localparam int N    = 12;
  localparam int NMIN = 2;
  localparam int HMAX = 4096;

  // {shift_en, din}
  localparam logic [8:0] STIM [24] = '{
    9'h1_11, 9'h1_22, 9'h0_E1, 9'h1_33, 9'h1_44, 9'h1_55, 9'h0_E2, 9'h0_E3,
    9'h1_66, 9'h1_77, 9'h1_88, 9'h1_99, 9'h1_AA, 9'h0_E4, 9'h1_BB, 9'h1_CC,
    9'h1_DD, 9'h1_01, 9'h0_E5, 9'h1_02, 9'h1_03, 9'h1_04, 9'h0_E6, 9'h1_05
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         shift_en;
  logic [W-1:0] din;
  logic [W-1:0] dout, dout_min;

  int tests = 0;
  int fails = 0;
  int k     = 0;
  logic [W-1:0] hist [HMAX];

  always #2 clk = ~clk;

  delay_line_ram #(.W(W), .N(N))    dut     (.clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din), .dout(dout));
  delay_line_ram #(.W(W), .N(NMIN)) dut_min (.clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din), .dout(dout_min));

  function automatic logic [W-1:0] expect_of(input int depth, input int cnt);
    if (cnt >= depth) return hist[cnt - depth];
    return '0;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (shift %0d)", req, act, exp, k);
    end
  endtask

  task automatic step(input logic en, input logic [W-1:0] d, input string req);
    @(negedge clk);
    shift_en = en;
    din      = d;
    @(posedge clk);
    #1;
    if (en && k < HMAX) begin
      hist[k] = d;
      k++;
    end
    check({req, " main"}, dout, expect_of(N, k));
    check({req, " R7 min depth"}, dout_min, expect_of(NMIN, k));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    shift_en = 1'b0;
    #1;
    check("R1 reset main", dout, '0);
    check("R1 reset min", dout_min, '0);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    shift_en = 1'b0;
    din      = '0;
    repeat (3) @(negedge clk);
    check("R1 reset main", dout, '0);
    rst_n = 1'b1;

    // Table walk: mixes stalls into the fill and first valid outputs (R2, R3, R4)
    foreach (STIM[i]) step(STIM[i][8], STIM[i][7:0], "R2/R3/R4 table");

    // Stalled value must never surface (R4): stall with a marker, then drain
    for (int i = 0; i < 4; i++) step(1'b0, 8'hEE, "R4 stall");
    for (int i = 0; i < N + 2; i++) begin
      step(1'b1, 8'(8'h40 + i), "R4 drain");
      check("R4 no stalled word", (dout == 8'hEE) ? 8'h1 : 8'h0, 8'h0);
    end

    // Many laps with random stalls (R5, R6)
    for (int i = 0; i < 1500; i++)
      step(($urandom_range(0, 3) != 0), 8'($urandom), "R5/R6 laps");

    // Reset mid-stream (R8)
    apply_reset();
    for (int i = 0; i < N + 3; i++) step(1'b1, 8'(8'hA0 + i), "R8 refill");

    // Back-to-back shifts only, across the wrap (R2, R5)
    for (int i = 0; i < 3 * N; i++) step(1'b1, 8'(i * 7 + 3), "R2/R5 continuous");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule